// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a processor port and a 512-byte window of peripheral registers whose registers have different native widths. The processor may issue byte, halfword or word accesses at any register. The adapter looks up the native width of the addressed 4-byte slot in a parameter table and turns each processor access into one or more peripheral accesses at exactly that width. When the processor access is narrower than the register, the adapter reads the whole register and returns the addressed lane; for a write, it also writes the register back with only that lane replaced. When the access is wider than the register, it splits the access into consecutive native-width pieces in big-endian order.

The peripheral port carries one native-width access per cycle and returns read data in the same cycle. A sequencer runs the sub-accesses back to back and reports completion with a single done strobe. Accesses outside the window, to an unmapped slot, with a misaligned address or with an undefined size code finish with an error flag and never reach the peripheral port.

Top module: `rwa_adapter`

## Requirements
- R1: While reset is held and directly after it, `cpu_busy`, `cpu_done`, `cpu_err` and `per_req` are low, and `cpu_rdata` is zero.
- R2: A request whose byte offset is 0x200 or higher finishes with `cpu_done` and `cpu_err` high in the cycle after acceptance, with `cpu_rdata` zero and no peripheral access.
- R3: The native-width code of slot `addr[8:2]` is 00 unmapped, 01 byte, 10 halfword, 11 word. The default table, repeating every 64 slots, gives slots 0-15 byte, 16-31 halfword, 32-47 word and 48-63 unmapped. A request to an unmapped slot finishes with an error and no peripheral access.
- R4: Size codes are 0 byte, 1 halfword, 2 word. Code 3, a halfword at an odd offset, or a word at an offset that is not a multiple of 4 finishes with an error and no peripheral access.
- R5: When the request size equals the native width, exactly one peripheral access is made at the request offset with the same size. Write data and read data pass unchanged and right-justified.
- R6: A read narrower than the register makes one read of the whole register at its aligned offset and returns the addressed lane. The lowest byte offset maps to the most significant lane, so a byte at an even halfword offset returns bits [15:8].
- R7: A write narrower than the register makes one read of the whole register and then, in the next cycle, one write of it at the same offset. Only the addressed lane is replaced in that write, using the big-endian lane mapping of R6.
- R8: A request wider than the register is split into request-size / native-width accesses at ascending offsets, each one native width apart. The lowest offset carries the most significant piece. Read pieces are joined in the same order.
- R9: Sub-accesses run in consecutive cycles starting the cycle after acceptance. `cpu_done` pulses for exactly one cycle, in the cycle after the last sub-access, and `cpu_busy` is high from acceptance until then.
- R10: A request is accepted only while `cpu_busy` is low. While busy, `cpu_req` and all request inputs are ignored, and the accepted request's captured values are used throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Request; taken when not busy |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 12 | Byte offset into the register window |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_busy | output | 1 | A request is in progress |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_err | output | 1 | Error, valid with done |
| cpu_rdata | output | 32 | Right-justified read data, valid with done for reads |
| per_req | output | 1 | Peripheral access this cycle |
| per_we | output | 1 | Peripheral write |
| per_size | output | 2 | Native width code, 0/1/2 as for cpu_size |
| per_addr | output | 9 | Peripheral byte offset |
| per_wdata | output | 32 | Right-justified peripheral write data |
| per_rdata | input | 32 | Peripheral read data, same cycle as per_req |

## Verification
The assertions assume that the peripheral returns read data in the same cycle that `per_req` is high. They also assume that the register contents change only through writes from this adapter, so a read-modify-write sees stable data between its two cycles. The bench models the peripheral as a byte array that answers combinationally and is written only on adapter writes. It changes the request inputs only between clock edges. It also keeps `cpu_req` asserted with altered fields during busy periods, so the tests cover the ignore-while-busy rule without ever violating the peripheral assumptions.

// File: rtl/rwa_pkg.sv
`timescale 1ns/1ps
package rwa_pkg;

  localparam int MAP_SLOTS = 128;

  typedef enum logic [2:0] {
    ST_IDLE, ST_XFER, ST_RMW_RD, ST_RMW_WR, ST_RESP
  } seq_state_e;

  // Default map: byte, half, word, unmapped in groups of 16 slots.
  function automatic logic [2*MAP_SLOTS-1:0] default_width_map();
    logic [2*MAP_SLOTS-1:0] m;
    m = '0;
    for (int s = 0; s < MAP_SLOTS; s++) begin
      case ((s / 16) % 4)
        0:       m[2*s +: 2] = 2'b01;
        1:       m[2*s +: 2] = 2'b10;
        2:       m[2*s +: 2] = 2'b11;
        default: m[2*s +: 2] = 2'b00;
      endcase
    end
    return m;
  endfunction

  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] code_bytes(logic [1:0] code);
    case (code)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] bytes_size(logic [2:0] n);
    case (n)
      3'd2:    return 2'd1;
      3'd4:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] byte_mask(logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      3'd4:    return 32'hffff_ffff;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic misaligned(logic [1:0] sz, logic [1:0] lo);
    case (sz)
      2'd1:    return lo[0];
      2'd2:    return |lo;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] piece_count(logic [2:0] s, logic [2:0] n);
    if (n == 3'd0)      return 3'd0;
    else if (s <= n)    return 3'd1;
    else if (n == 3'd1) return s;
    else                return s >> 1;
  endfunction

  // Byte offset of piece k of native width n.
  function automatic logic [4:0] piece_offset(logic [2:0] k, logic [2:0] n);
    case (n)
      3'd2:    return {1'b0, k, 1'b0};
      3'd4:    return {k, 2'b00};
      default: return {2'b00, k};
    endcase
  endfunction

  // Piece k of an s-byte value cut into n-byte pieces, most significant first.
  function automatic logic [31:0] split_piece(logic [31:0] w, logic [2:0] s,
                                              logic [2:0] n, logic [2:0] k);
    logic [2:0] below;
    below = s - n * (k + 3'd1);
    return (w >> {below[1:0], 3'b000}) & byte_mask(n);
  endfunction

  function automatic logic [31:0] join_piece(logic [31:0] acc, logic [31:0] d,
                                             logic [2:0] n);
    case (n)
      3'd1:    return {acc[23:0], d[7:0]};
      3'd2:    return {acc[15:0], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] lane_extract(logic [31:0] d, logic [1:0] sh,
                                               logic [2:0] s);
    return (d >> {sh, 3'b000}) & byte_mask(s);
  endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] d, logic [31:0] w,
                                             logic [1:0] sh, logic [2:0] s);
    return (d & ~(byte_mask(s) << {sh, 3'b000})) |
           ((w & byte_mask(s)) << {sh, 3'b000});
  endfunction

endpackage

// File: rtl/rwa_decode.sv
`timescale 1ns/1ps
module rwa_decode import rwa_pkg::*; #(
  parameter int ADDR_W      = 12,
  parameter int SPACE_BYTES = 512,
  parameter logic [2*(SPACE_BYTES/4)-1:0] WIDTH_MAP = default_width_map()
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [1:0]                          size,
  output logic                                err,
  output logic                                rmw,
  output logic [2:0]                          cpu_bytes,
  output logic [2:0]                          nat_bytes,
  output logic [2:0]                          nops,
  output logic [1:0]                          shift,
  output logic [$clog2(SPACE_BYTES)-1:0]      base
);
  localparam int PA_W   = $clog2(SPACE_BYTES);
  localparam int SLOT_W = PA_W - 2;

  logic              in_range;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        code;
  logic [2:0]        lane_off;

  generate
    if (ADDR_W > PA_W) begin : g_range
      assign in_range = ~|addr[ADDR_W-1:PA_W];
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign slot = addr[PA_W-1:2];
  assign code = WIDTH_MAP[{slot, 1'b0} +: 2];

  always_comb begin
    cpu_bytes = size_bytes(size);
    nat_bytes = code_bytes(code);
    err       = !in_range || (code == 2'b00) || (size == 2'd3) ||
                misaligned(size, addr[1:0]);
    rmw       = (cpu_bytes < nat_bytes);
    nops      = piece_count(cpu_bytes, nat_bytes);
    lane_off  = {1'b0, addr[1:0] & 2'(nat_bytes - 3'd1)};
    shift     = rmw ? 2'(nat_bytes - lane_off - cpu_bytes) : 2'd0;
    base      = rmw ? (addr[PA_W-1:0] & ~PA_W'(nat_bytes - 3'd1))
                    : addr[PA_W-1:0];
  end
endmodule

// File: rtl/rwa_sequencer.sv
`timescale 1ns/1ps
module rwa_sequencer import rwa_pkg::*; #(
  parameter int PA_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [31:0]     cpu_wdata,
  input  logic            dec_err,
  input  logic            dec_rmw,
  input  logic [2:0]      dec_cpu_bytes,
  input  logic [2:0]      dec_nat_bytes,
  input  logic [2:0]      dec_nops,
  input  logic [1:0]      dec_shift,
  input  logic [PA_W-1:0] dec_base,
  output logic            ev_accept,
  output logic            cpu_busy,
  output logic            cpu_done,
  output logic            cpu_err,
  output logic [31:0]     cpu_rdata,
  output logic            per_req,
  output logic            per_we,
  output logic [1:0]      per_size,
  output logic [PA_W-1:0] per_addr,
  output logic [31:0]     per_wdata,
  input  logic [31:0]     per_rdata
);
  seq_state_e      state;
  logic            r_we, r_err;
  logic [31:0]     r_wdata, r_hold, r_acc;
  logic [2:0]      r_s, r_n, r_nops, r_k;
  logic [1:0]      r_shift;
  logic [PA_W-1:0] r_base;

  logic ev_split_step, ev_rmw_read, ev_rmw_write, last_piece;

  assign ev_accept     = (state == ST_IDLE) && cpu_req;
  assign last_piece    = (r_k == r_nops - 3'd1);
  assign ev_split_step = (state == ST_XFER) && !last_piece;
  assign ev_rmw_read   = (state == ST_RMW_RD);
  assign ev_rmw_write  = (state == ST_RMW_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_we    <= 1'b0;
      r_err   <= 1'b0;
      r_wdata <= '0;
      r_hold  <= '0;
      r_acc   <= '0;
      r_s     <= '0;
      r_n     <= '0;
      r_nops  <= '0;
      r_k     <= '0;
      r_shift <= '0;
      r_base  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cpu_req) begin
          r_we    <= cpu_we;
          r_wdata <= cpu_wdata;
          r_err   <= dec_err;
          r_s     <= dec_cpu_bytes;
          r_n     <= dec_nat_bytes;
          r_nops  <= dec_nops;
          r_shift <= dec_shift;
          r_base  <= dec_base;
          r_k     <= '0;
          r_acc   <= '0;
          if (dec_err)      state <= ST_RESP;
          else if (dec_rmw) state <= ST_RMW_RD;
          else              state <= ST_XFER;
        end
        ST_XFER: begin
          r_acc <= join_piece(r_acc, per_rdata, r_n);
          if (last_piece) state <= ST_RESP;
          else            r_k   <= r_k + 3'd1;
        end
        ST_RMW_RD: begin
          r_hold <= per_rdata;
          r_acc  <= lane_extract(per_rdata, r_shift, r_s);
          state  <= r_we ? ST_RMW_WR : ST_RESP;
        end
        ST_RMW_WR: state <= ST_RESP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    per_req   = (state == ST_XFER) || ev_rmw_read || ev_rmw_write;
    per_we    = ((state == ST_XFER) && r_we) || ev_rmw_write;
    per_size  = bytes_size(r_n);
    per_addr  = (state == ST_XFER) ? r_base + PA_W'(piece_offset(r_k, r_n))
                                   : r_base;
    if ((state == ST_XFER) && r_we) per_wdata = split_piece(r_wdata, r_s, r_n, r_k);
    else if (ev_rmw_write)          per_wdata = lane_merge(r_hold, r_wdata, r_shift, r_s);
    else                            per_wdata = '0;
    cpu_busy  = (state != ST_IDLE);
    cpu_done  = (state == ST_RESP);
    cpu_err   = cpu_done && r_err;
    cpu_rdata = (cpu_done && !r_we && !r_err) ? r_acc : '0;
  end

  // R9: completion strobe lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  // R2: error flag only accompanies completion
  p_err_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_done);
  // R7: write-back immediately follows the register read
  p_rmw_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_write |-> $past(ev_rmw_read));
  // R8: split pieces advance by one native width
  p_split_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_split_step |=> (per_addr == PA_W'($past(per_addr) + PA_W'($past(r_n)))));
endmodule

// File: rtl/rwa_adapter.sv
`timescale 1ns/1ps
module rwa_adapter import rwa_pkg::*; #(
  parameter int ADDR_W      = 12,
  parameter int SPACE_BYTES = 512,
  parameter logic [2*(SPACE_BYTES/4)-1:0] WIDTH_MAP = default_width_map()
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req,
  input  logic                           cpu_we,
  input  logic [1:0]                     cpu_size,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [31:0]                    cpu_wdata,
  output logic                           cpu_busy,
  output logic                           cpu_done,
  output logic                           cpu_err,
  output logic [31:0]                    cpu_rdata,
  output logic                           per_req,
  output logic                           per_we,
  output logic [1:0]                     per_size,
  output logic [$clog2(SPACE_BYTES)-1:0] per_addr,
  output logic [31:0]                    per_wdata,
  input  logic [31:0]                    per_rdata
);
  localparam int PA_W = $clog2(SPACE_BYTES);

  logic            dec_err, dec_rmw, ev_accept;
  logic [2:0]      dec_cpu_bytes, dec_nat_bytes, dec_nops;
  logic [1:0]      dec_shift;
  logic [PA_W-1:0] dec_base;

  rwa_decode #(
    .ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES), .WIDTH_MAP(WIDTH_MAP)
  ) u_decode (
    .addr(cpu_addr), .size(cpu_size), .err(dec_err), .rmw(dec_rmw),
    .cpu_bytes(dec_cpu_bytes), .nat_bytes(dec_nat_bytes), .nops(dec_nops),
    .shift(dec_shift), .base(dec_base)
  );

  rwa_sequencer #(.PA_W(PA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .dec_err(dec_err), .dec_rmw(dec_rmw),
    .dec_cpu_bytes(dec_cpu_bytes), .dec_nat_bytes(dec_nat_bytes),
    .dec_nops(dec_nops), .dec_shift(dec_shift), .dec_base(dec_base),
    .ev_accept(ev_accept), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .cpu_err(cpu_err), .cpu_rdata(cpu_rdata), .per_req(per_req),
    .per_we(per_we), .per_size(per_size), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  // R3, R4: a rejected request never reaches the peripheral port
  p_no_access_on_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && dec_err) |=> !per_req);
  // R2: a rejected request completes with the error flag next cycle
  p_err_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && dec_err) |=> (cpu_done && cpu_err));
endmodule

// File: tb/rwa_adapter_test.sv
`timescale 1ns/1ps
module rwa_adapter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_busy, cpu_done, cpu_err, per_req, per_we;
  logic [31:0] cpu_rdata, per_wdata, per_rdata;
  logic [1:0]  per_size;
  logic [8:0]  per_addr;

  logic [7:0] mem [0:511];
  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  rwa_adapter uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_err(cpu_err),
    .cpu_rdata(cpu_rdata), .per_req(per_req), .per_we(per_we),
    .per_size(per_size), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  // Peripheral model: big-endian byte store, combinational read.
  function automatic int nb_of(logic [1:0] c);
    return (c == 2'd2) ? 4 : (c == 2'd1) ? 2 : 1;
  endfunction

  always_comb begin
    per_rdata = '0;
    for (int i = 0; i < nb_of(per_size); i++)
      per_rdata = {per_rdata[23:0], mem[(int'(per_addr) + i) % 512]};
  end

  always @(posedge clk) begin
    if (per_req && per_we)
      for (int i = 0; i < nb_of(per_size); i++)
        mem[(int'(per_addr) + i) % 512] <= 8'(per_wdata >> (8 * (nb_of(per_size) - 1 - i)));
  end

  function automatic int native(int a);
    if (a >= 512) return 0;
    case (((a / 4) % 64) / 16)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] code_of(int n);
    return (n == 4) ? 2'd2 : (n == 2) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [31:0] be_read(int a, int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[23:0], mem[a + i]};
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(string tag, bit we, logic [1:0] szc, int a,
                        logic [31:0] wd, bit hold);
    int sb, n, nops, base;
    bit err;
    logic [31:0] oa [4];
    logic        oe [4];
    logic [1:0]  os [4];
    logic [31:0] od [4];
    logic [7:0]  wb [4];
    logic [31:0] erd, d;
    sb   = (szc == 2'd3) ? 1 : nb_of(szc);
    n    = native(a);
    err  = (szc == 2'd3) || (a >= 512) || (n == 0) || ((a % sb) != 0);
    nops = 0;
    erd  = '0;
    for (int i = 0; i < 4; i++) begin
      oa[i] = '0; oe[i] = 1'b0; os[i] = '0; od[i] = '0;
      wb[i] = (i < sb) ? 8'(wd >> (8 * (sb - 1 - i))) : 8'h00;
    end
    if (!err) begin
      if (sb >= n) begin
        nops = sb / n;
        for (int k = 0; k < nops; k++) begin
          d = '0;
          if (we) for (int j = 0; j < n; j++) d = {d[23:0], wb[k * n + j]};
          oa[k] = 32'(a + k * n); oe[k] = we; os[k] = code_of(n); od[k] = d;
        end
      end else begin
        base  = a - (a % n);
        nops  = 1;
        oa[0] = 32'(base); os[0] = code_of(n);
        if (we) begin
          d = '0;
          for (int j = 0; j < n; j++)
            d = {d[23:0], ((base + j >= a) && (base + j < a + sb)) ? wb[base + j - a]
                                                                 : mem[base + j]};
          nops = 2;
          oa[1] = 32'(base); oe[1] = 1'b1; os[1] = code_of(n); od[1] = d;
        end
      end
      if (!we) erd = be_read(a, sb);
    end

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_size = szc; cpu_addr = 12'(a); cpu_wdata = wd;
    for (int k = 0; k < nops; k++) begin
      @(negedge clk);
      chk(tag, "per_req", 32'(per_req), 32'd1);
      chk(tag, "per_addr", 32'(per_addr), oa[k]);
      chk(tag, "per_we", 32'(per_we), 32'(oe[k]));
      chk(tag, "per_size", 32'(per_size), 32'(os[k]));
      chk(tag, "per_wdata", per_wdata, od[k]);
      chk("R9", "cpu_done mid", 32'(cpu_done), 32'd0);
      chk("R9", "cpu_busy mid", 32'(cpu_busy), 32'd1);
      if (hold) begin
        cpu_addr = 12'h0C1; cpu_wdata = ~wd; cpu_we = ~we; cpu_size = 2'd3;
      end else cpu_req = 1'b0;
    end
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R9", "cpu_done", 32'(cpu_done), 32'd1);
    chk("R9", "per_req at done", 32'(per_req), 32'd0);
    chk(tag, "cpu_err", 32'(cpu_err), 32'(err));
    chk(tag, "cpu_rdata", cpu_rdata, erd);
    @(negedge clk);
    chk("R9", "cpu_done after", 32'(cpu_done), 32'd0);
    chk("R9", "cpu_busy after", 32'(cpu_busy), 32'd0);
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) & 8'hff);
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", 32'(cpu_busy), 32'd0);
    chk("R1", "done in reset", 32'(cpu_done), 32'd0);
    chk("R1", "per_req in reset", 32'(per_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "err after reset", 32'(cpu_err), 32'd0);
    chk("R1", "rdata after reset", cpu_rdata, 32'd0);
    chk("R1", "busy after reset", 32'(cpu_busy), 32'd0);

    // R5: matched widths
    access("R5", 1, 2'd0, 'h005, 32'hA7, 0);
    access("R5", 0, 2'd0, 'h005, 0, 0);
    access("R5", 1, 2'd1, 'h040, 32'hBEEF, 0);
    access("R5", 0, 2'd1, 'h040, 0, 0);
    access("R5", 1, 2'd2, 'h080, 32'h1234_5678, 0);
    access("R5", 0, 2'd2, 'h080, 0, 0);
    // R6: narrow reads
    access("R6", 0, 2'd0, 'h040, 0, 0);
    access("R6", 0, 2'd0, 'h041, 0, 0);
    access("R6", 0, 2'd0, 'h081, 0, 0);
    access("R6", 0, 2'd1, 'h082, 0, 0);
    // R7: narrow writes
    access("R7", 1, 2'd0, 'h045, 32'h5A, 0);
    access("R7", 0, 2'd1, 'h044, 0, 0);
    access("R7", 1, 2'd1, 'h086, 32'hCAFE, 0);
    access("R7", 1, 2'd1, 'h084, 32'h1357, 0);
    access("R7", 1, 2'd0, 'h08B, 32'h9C, 0);
    access("R7", 0, 2'd2, 'h088, 0, 0);
    access("R7", 0, 2'd2, 'h084, 0, 0);
    // R8: wide accesses split
    access("R8", 1, 2'd1, 'h010, 32'h1234, 0);
    access("R8", 0, 2'd1, 'h010, 0, 0);
    access("R8", 0, 2'd0, 'h011, 0, 0);
    access("R8", 1, 2'd2, 'h048, 32'hDEAD_BEEF, 0);
    access("R8", 0, 2'd2, 'h048, 0, 0);
    access("R8", 1, 2'd2, 'h020, 32'hA1B2_C3D4, 0);
    access("R8", 0, 2'd2, 'h020, 0, 0);
    access("R8", 1, 2'd2, 'h150, 32'h7777_8888, 0);
    access("R8", 0, 2'd0, 'h151, 0, 0);
    // R10: request held with altered fields while busy
    access("R10", 1, 2'd2, 'h024, 32'h0F1E_2D3C, 1);
    access("R10", 0, 2'd2, 'h024, 0, 1);
    access("R10", 1, 2'd0, 'h0A3, 32'h66, 1);
    access("R10", 0, 2'd2, 'h0A0, 0, 0);
    // R3: unmapped slots
    access("R3", 0, 2'd0, 'h0C0, 0, 0);
    access("R3", 1, 2'd2, 'h1C4, 32'hFFFF_FFFF, 0);
    access("R3", 0, 2'd2, 'h1C4, 0, 0);
    // R2: out of range
    access("R2", 0, 2'd0, 'h200, 0, 0);
    access("R2", 1, 2'd2, 'hFFC, 32'h1111_2222, 1);
    // R4: misaligned and undefined size
    access("R4", 0, 2'd1, 'h041, 0, 0);
    access("R4", 1, 2'd2, 'h082, 32'h5555_5555, 0);
    access("R4", 0, 2'd3, 'h000, 0, 0);
    access("R4", 0, 2'd2, 'h080, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule